// File: doc/BRIEF.md
# Command-Driven Packet Network Interface

This block is a memory-mapped network port built around a single packet buffer that software fills before a send and reads after a receive. The packet buffer sits at the bottom of the register window. A length register, a command register and a status word sit above it, and one level interrupt reports the status. On the network side, the block drives an outgoing byte stream that marks the first and last byte of each packet. It always accepts an incoming byte stream and stores whole frames in a small queue of frame slots.

Incoming frames are not delivered on their own. Software issues a "receive" command, and the oldest queued frame is copied byte by byte into the shared buffer. The status word then reports that a frame arrived and whether more frames are still waiting. A "send" command streams the programmed number of buffer bytes onto the outgoing stream. The status word clears when it is read, and the interrupt follows it.

Top module: `nic_pkt_if`

## Requirements
- R1: After reset, irq is low, tx_valid is low, and reads of the status word (0x4000) and of the length register (0x4010) return 0.
- R2: Bus offsets below BUF_BYTES read and write the buffer byte at that index. Data sits in bus_rdata[7:0] with the upper bits zero. A read at an offset from BUF_BYTES up to 0x3FFF returns 0.
- R3: Writing 0x0000 to the command register (0x4020) while a frame is queued copies that frame into the buffer from index 0. When the copy is done, the length register reads the frame's byte count and status bit 0 is set.
- R4: When a receive completes, status bit 1 is set if the queue still holds a frame. This includes a frame whose last byte is accepted in the same cycle as the copy completes.
- R5: A receive command with an empty queue leaves status bit 0 clear and sets the length register to 0.
- R6: irq is high exactly when the status word is non-zero. A status read returns the current bits and clears them, so irq is low in the next cycle unless a new event sets a bit in that same cycle.
- R7: Writing 0x0001 to the command register sends buffer bytes from index 0 upward, one per cycle in which tx_ready is high. tx_first marks the first byte and tx_last the final byte, and a byte stays stable while tx_ready is low.
- R8: The number of bytes sent is the value last written to the length register, limited to BUF_BYTES. A length of 0 sends nothing.
- R9: Command writes during a send or a receive copy are ignored, and so are command values other than 0x0000 and 0x0001.
- R10: The queue holds up to RX_FRAMES frames and delivers them oldest first. A frame whose first byte arrives while the queue is full is dropped entirely.
- R11: An incoming frame longer than BUF_BYTES keeps its first BUF_BYTES bytes and reports a length of BUF_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 15 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a status read clears the status word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, high while the status word is non-zero |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_first | output | 1 | First byte of the packet |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Incoming byte valid (always accepted) |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of the incoming frame |

## Verification
A receive copy can complete in the same cycle as the incoming stream finishes another frame. In that cycle the queue both pops and commits, and the "more waiting" bit must count the new frame. The bench queues one four-byte frame and issues a receive. It then starts a three-byte frame so that its last byte is taken at the edge that ends the four-cycle copy, and it expects the status word to read 3 instead of 1. A later receive must return the three-byte frame intact, which shows the pop and commit did not disturb each other's slot.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } nic_state_e;

    localparam logic [14:0] OFF_STATUS = 15'h4000;
    localparam logic [14:0] OFF_LEN    = 15'h4010;
    localparam logic [14:0] OFF_CMD    = 15'h4020;

    localparam logic [15:0] CMD_RECV = 16'h0000;
    localparam logic [15:0] CMD_SEND = 16'h0001;

    localparam int STAT_GOT  = 0;
    localparam int STAT_MORE = 1;

endpackage

// File: rtl/nic_pkt_buf.sv
module nic_pkt_buf #(
    parameter int BUF_BYTES = 64,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [7:0]       bus_wbyte,
    output logic [7:0]       bus_rbyte,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_wbyte,
    output logic [7:0]       eng_rbyte
);
    logic [7:0] mem_q [BUF_BYTES];

    // Engine writes win over the bus when both target the array.
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem_q[eng_idx] <= eng_wbyte;
        end else if (bus_we) begin
            mem_q[bus_idx] <= bus_wbyte;
        end
    end

    assign bus_rbyte = mem_q[bus_idx];
    assign eng_rbyte = mem_q[eng_idx];
endmodule

// File: rtl/nic_rx_queue.sv
module nic_rx_queue #(
    parameter int BUF_BYTES = 64,
    parameter int RX_FRAMES = 2,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int LEN_W  = $clog2(BUF_BYTES + 1),
    localparam int SLOT_W = (RX_FRAMES > 1) ? $clog2(RX_FRAMES) : 1,
    localparam int CNT_W  = $clog2(RX_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             pop,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic             commit,
    output logic [LEN_W-1:0] head_len,
    output logic [7:0]       head_byte
);
    localparam logic [LEN_W-1:0]  BUF_LEN   = LEN_W'(BUF_BYTES);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(RX_FRAMES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RX_FRAMES - 1);

    typedef struct packed {
        logic              in_frame;
        logic              drop;
        logic [LEN_W-1:0]  wcnt;
        logic [SLOT_W-1:0] wp;
        logic [SLOT_W-1:0] rp;
        logic [CNT_W-1:0]  count;
    } rxq_t;

    rxq_t r_q, r_d;
    logic [7:0]       mem_q  [RX_FRAMES][BUF_BYTES];
    logic [LEN_W-1:0] flen_q [RX_FRAMES];

    logic             first_beat, take, store;
    logic [LEN_W-1:0] final_len;

    always_comb begin
        r_d        = r_q;
        first_beat = rx_valid && !r_q.in_frame;
        take       = first_beat ? (r_q.count != FULL_CNT) : !r_q.drop;
        store      = rx_valid && take && (r_q.wcnt < BUF_LEN);
        commit     = rx_valid && rx_last && take;
        final_len  = (r_q.wcnt < BUF_LEN) ? r_q.wcnt + LEN_W'(1) : BUF_LEN;

        if (rx_valid) begin
            r_d.in_frame = !rx_last;
            r_d.drop     = rx_last ? 1'b0 : (first_beat ? !take : r_q.drop);
            if (rx_last) begin
                r_d.wcnt = '0;
            end else if (r_q.wcnt != BUF_LEN) begin
                r_d.wcnt = r_q.wcnt + LEN_W'(1);
            end
        end
        if (commit) begin
            r_d.wp = (r_q.wp == LAST_SLOT) ? '0 : r_q.wp + SLOT_W'(1);
        end
        if (pop) begin
            r_d.rp = (r_q.rp == LAST_SLOT) ? '0 : r_q.rp + SLOT_W'(1);
        end
        r_d.count = r_q.count + CNT_W'(commit) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (store) begin
            mem_q[r_q.wp][r_q.wcnt[IDX_W-1:0]] <= rx_data;
        end
        if (commit) begin
            flen_q[r_q.wp] <= final_len;
        end
    end

    assign count     = r_q.count;
    assign head_len  = flen_q[r_q.rp];
    assign head_byte = mem_q[r_q.rp][rd_idx];

    // R10: occupancy never passes the slot count
    assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= FULL_CNT);

    // R10: a frame only commits into a free slot
    assert_no_commit_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (r_q.count != FULL_CNT));
endmodule

// File: rtl/nic_pkt_if.sv
module nic_pkt_if
    import nic_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int RX_FRAMES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [14:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_first,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    // BUF_BYTES: power of two, at most 8192
    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int LEN_W = $clog2(BUF_BYTES + 1);
    localparam int CNT_W = $clog2(RX_FRAMES + 1);
    localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);
    localparam logic [15:0]      BUF_W16 = 16'(BUF_BYTES);
    localparam logic [13:0]      BUF_END = 14'(BUF_BYTES);

    typedef struct packed {
        nic_state_e       state;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] xfer;
        logic [15:0]      tx_len;
        logic [LEN_W-1:0] rx_len;
        logic [1:0]       status;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             in_buf, hit_status, hit_len, hit_cmd;
    logic             cmd_wr, status_rd, pop, eng_we;
    logic [CNT_W-1:0] q_count;
    logic             q_commit;
    logic [LEN_W-1:0] q_head_len, send_len;
    logic [7:0]       q_head_byte, bus_rbyte, eng_rbyte;
    logic [IDX_W-1:0] eng_idx;

    assign in_buf     = !bus_addr[14] && (bus_addr[13:0] < BUF_END);
    assign hit_status = (bus_addr == OFF_STATUS);
    assign hit_len    = (bus_addr == OFF_LEN);
    assign hit_cmd    = (bus_addr == OFF_CMD);
    assign cmd_wr     = bus_wr && hit_cmd;
    assign status_rd  = bus_rd && hit_status;
    assign eng_idx    = c_q.cnt[IDX_W-1:0];
    assign send_len   = (c_q.tx_len > BUF_W16) ? BUF_LEN : c_q.tx_len[LEN_W-1:0];

    always_comb begin
        c_d    = c_q;
        pop    = 1'b0;
        eng_we = 1'b0;

        if (bus_wr && hit_len) begin
            c_d.tx_len = bus_wdata;
        end
        // Clear first so that bits set below in the same cycle survive.
        if (status_rd) begin
            c_d.status = 2'b00;
        end

        unique case (c_q.state)
            ST_IDLE: begin
                if (cmd_wr && bus_wdata == CMD_RECV) begin
                    if (q_count != '0) begin
                        c_d.state = ST_FETCH;
                        c_d.cnt   = '0;
                        c_d.xfer  = q_head_len;
                    end else begin
                        c_d.rx_len = '0;
                        if (q_commit) begin
                            c_d.status[STAT_MORE] = 1'b1;
                        end
                    end
                end else if (cmd_wr && bus_wdata == CMD_SEND && send_len != '0) begin
                    c_d.state = ST_SEND;
                    c_d.cnt   = '0;
                    c_d.xfer  = send_len;
                end
            end
            ST_FETCH: begin
                eng_we = 1'b1;
                if (c_q.cnt == c_q.xfer - LEN_W'(1)) begin
                    pop                  = 1'b1;
                    c_d.state            = ST_IDLE;
                    c_d.rx_len           = c_q.xfer;
                    c_d.status[STAT_GOT] = 1'b1;
                    if (q_count != CNT_W'(1) || q_commit) begin
                        c_d.status[STAT_MORE] = 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + LEN_W'(1);
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (c_q.cnt == c_q.xfer - LEN_W'(1)) begin
                        c_d.state = ST_IDLE;
                    end else begin
                        c_d.cnt = c_q.cnt + LEN_W'(1);
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    nic_rx_queue #(.BUF_BYTES(BUF_BYTES), .RX_FRAMES(RX_FRAMES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .pop       (pop),
        .rd_idx    (eng_idx),
        .count     (q_count),
        .commit    (q_commit),
        .head_len  (q_head_len),
        .head_byte (q_head_byte)
    );

    nic_pkt_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk       (clk),
        .bus_we    (bus_wr && in_buf),
        .bus_idx   (bus_addr[IDX_W-1:0]),
        .bus_wbyte (bus_wdata[7:0]),
        .bus_rbyte (bus_rbyte),
        .eng_we    (eng_we),
        .eng_idx   (eng_idx),
        .eng_wbyte (q_head_byte),
        .eng_rbyte (eng_rbyte)
    );

    always_comb begin
        bus_rdata = 16'h0000;
        if (in_buf) begin
            bus_rdata = {8'h00, bus_rbyte};
        end else if (hit_status) begin
            bus_rdata = {14'h0000, c_q.status};
        end else if (hit_len) begin
            bus_rdata = 16'(c_q.rx_len);
        end
    end

    assign irq      = |c_q.status;
    assign tx_valid = (c_q.state == ST_SEND);
    assign tx_data  = eng_rbyte;
    assign tx_first = tx_valid && (c_q.cnt == '0);
    assign tx_last  = tx_valid && (c_q.cnt == c_q.xfer - LEN_W'(1));

    // R6: an idle status read with no command leaves the interrupt low next cycle
    assert_read_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && c_q.state == ST_IDLE && !cmd_wr) |=> !irq);

    // R7: a stalled byte holds its value and markers
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: an accepted send begins with the first-byte marker
    assert_send_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && cmd_wr && bus_wdata == CMD_SEND && c_q.tx_len != '0)
        |=> (tx_valid && tx_first));

    // R9: a command during a send never starts a receive copy
    assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_SEND && cmd_wr) |=> (c_q.state != ST_FETCH));
endmodule

// File: tb/tb_nic_pkt_if.sv
`timescale 1ns/1ps
module tb_nic_pkt_if;
    localparam int BUF = 64;
    localparam logic [14:0] A_STAT = 15'h4000;
    localparam logic [14:0] A_LEN  = 15'h4010;
    localparam logic [14:0] A_CMD  = 15'h4020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, tx_valid, tx_first, tx_last;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;

    int tests = 0, fails = 0, beats = 0, cyc = 0;
    bit stall = 1'b0, done = 1'b0;
    logic [9:0] exp_q [$];
    logic [7:0] model [BUF];

    always #2.5 clk = ~clk;

    nic_pkt_if #(.BUF_BYTES(BUF), .RX_FRAMES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rx(input string req, input int n, input logic [7:0] seed, input int stat);
        logic [15:0] v;
        bus_read(A_STAT, v);
        check(v == 16'(stat), req, v, stat);
        bus_read(A_LEN, v);
        check(v == 16'(n), req, v, n);
        for (int i = 0; i < n; i++) begin
            bus_read(15'(i), v);
            check(v == {8'h00, seed + 8'(i)}, req, v, seed + 8'(i));
        end
    endtask

    task automatic do_send(input int prog);
        int n;
        n = (prog > BUF) ? BUF : prog;
        bus_write(A_LEN, 16'(prog));
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({i == 0, i == n - 1, model[i]});
        end
        bus_write(A_CMD, 16'h0001);
    endtask

    // Scoreboard monitor: pops one expected beat per accepted output byte.
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            cyc++;
            #1;
            if (tx_valid && tx_ready) begin
                beats++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected beat", tx_data, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check({tx_first, tx_last, tx_data} == e, "R7 beat", {tx_first, tx_last, tx_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int b0;
        wait_cycles(4);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        bus_read(A_STAT, v); check(v == 0, "R1 status", v, 0);
        bus_read(A_LEN, v);  check(v == 0, "R1 length", v, 0);

        // R2 buffer access and out-of-range read
        bus_write(15'd3, 16'h00A5);
        bus_write(15'd63, 16'h005A);
        bus_read(15'd3, v);  check(v == 16'h00A5, "R2 idx3", v, 16'h00A5);
        bus_read(15'd63, v); check(v == 16'h005A, "R2 idx63", v, 16'h005A);
        bus_read(15'd69, v); check(v == 16'h0000, "R2 out of range", v, 0);

        // R5 empty receive after reset
        bus_write(A_CMD, 16'h0000);
        wait_cycles(4);
        check(irq == 1'b0, "R5 no irq", irq, 0);
        bus_read(A_STAT, v); check(v == 0, "R5 status", v, 0);

        // R3 / R6 single frame
        rx_frame(5, 8'h10);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        check(irq == 1'b1, "R6 irq set", irq, 1);
        expect_rx("R3 frame", 5, 8'h10, 1);
        #1 check(irq == 1'b0, "R6 irq cleared", irq, 0);

        // R10 FIFO order and drop when full, R4 more bit
        rx_frame(3, 8'h20);
        rx_frame(4, 8'h30);
        rx_frame(2, 8'h70);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        expect_rx("R4 R10 oldest first", 3, 8'h20, 3);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        expect_rx("R10 second frame", 4, 8'h30, 1);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(8);
        bus_read(A_STAT, v); check(v == 0, "R10 dropped frame absent", v, 0);
        bus_read(A_LEN, v);  check(v == 0, "R5 length zero", v, 0);

        // R11 truncation
        rx_frame(70, 8'h80);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        expect_rx("R11 truncated", BUF, 8'h80, 1);

        // R4 pop and commit in the same cycle
        rx_frame(4, 8'h40);
        bus_write(A_CMD, 16'h0000);
        rx_frame(3, 8'h60);
        wait_cycles(BUF + 8);
        bus_read(A_STAT, v); check(v == 3, "R4 coincident commit", v, 3);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        expect_rx("R4 coincident frame", 3, 8'h60, 1);

        // R7 / R8 sends
        for (int i = 0; i < BUF; i++) begin
            model[i] = 8'(i * 7 + 3);
            bus_write(15'(i), 16'(model[i]));
        end
        stall = 1'b1;
        b0 = beats;
        do_send(6);
        wait_cycles(40);
        check(beats - b0 == 6, "R7 six beats", beats - b0, 6);
        b0 = beats;
        do_send(200);
        wait_cycles(200);
        check(beats - b0 == BUF, "R8 clamp", beats - b0, BUF);
        b0 = beats;
        do_send(0);
        wait_cycles(20);
        check(beats - b0 == 0, "R8 zero length", beats - b0, 0);

        // R9 commands ignored while sending, unknown codes ignored
        rx_frame(3, 8'h50);
        b0 = beats;
        do_send(20);
        bus_write(A_CMD, 16'h0000);
        bus_write(A_CMD, 16'h0001);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(80);
        check(beats - b0 == 20, "R9 single send", beats - b0, 20);
        check(irq == 1'b0, "R9 no receive", irq, 0);
        bus_write(A_CMD, 16'h0005);
        wait_cycles(10);
        check(tx_valid == 1'b0 && irq == 1'b0, "R9 unknown code", {tx_valid, irq}, 0);
        bus_write(A_CMD, 16'h0000);
        wait_cycles(BUF + 8);
        expect_rx("R9 frame kept", 3, 8'h50, 1);

        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule